// File: doc/BRIEF.md
# Segment Descriptor Loader

When a selector is written into a segment register, this block fetches the selected eight-byte segment descriptor from a descriptor table in memory. It reads the descriptor as four 16-bit words through a request/ready memory port. It reassembles the base and limit, which are split across the descriptor, and turns the 20-bit limit field into a 32-bit byte limit. It then decides whether the descriptor may be placed in the requested register: a code register, the stack register, or a data register.

A legal and present descriptor loads the hidden cache outputs. If the descriptor's accessed bit was clear, the block first sets it in memory with one word write. A load that is refused ends with either a general protection flag or a not-present flag, and leaves the cache outputs as they were. The sequencer above the block starts a load with a one-cycle request and waits for a one-cycle completion pulse.

Top module: `seg_desc_loader`

## Requirements
- R1: An accepted load issues exactly four word reads, at D+0, D+2, D+4 and D+6 in that order. D is the table base plus eight times the selector index, and the index is selector bits 15..3. Selector bits 2..0 do not affect the address.
- R2: Descriptor bytes are little-endian and are byte 0 at D. On success the cache outputs take these fields. Base is byte 7 in bits 31..24, with bytes 4, 3, 2 below it. The access byte is byte 5, with bit 0 forced to 1. DPL is byte 5 bits 6..5. Granularity is byte 6 bit 7, big/default is byte 6 bit 6, and the software-available bit is byte 6 bit 4. The 20-bit limit field is byte 6 bits 3..0 above bytes 1..0.
- R3: With granularity 0 the cache limit is the limit field zero-extended. With granularity 1 it is the field shifted left by 12 with the low 12 bits set. A field of 0 with granularity 1 gives 0x00000FFF, for expand-down data descriptors too.
- R4: Target code 2'b01 selects the code register. It accepts a descriptor only if the access-byte executable bit (bit 3) is 1, and the readable bit (bit 1) has no effect.
- R5: Target code 2'b10 selects the stack register. It accepts only a data descriptor (bit 3 = 0) whose writable bit (bit 1) is 1. Any other descriptor gives a protection fault.
- R6: Target codes 2'b00 and 2'b11 select a data register. It accepts any data descriptor and any executable descriptor with bit 1 = 1. An executable descriptor with bit 1 = 0 gives a protection fault.
- R7: A descriptor whose system/segment bit (access bit 4) is 0 gives a protection fault.
- R8: A descriptor that passes the type checks but has the present bit (access bit 7) equal to 0 gives a not-present fault. The type checks take priority over the present check.
- R9: After a successful fetch whose access bit 0 was 0, the block issues exactly one word write to D+4. The write carries byte 4 in the low half and the access byte with bit 0 set in the high half. When bit 0 was already 1, or when the load faults, no write is issued.
- R10: If the index offset plus 7 is greater than the table limit input, the load ends with a protection fault and makes no memory access.
- R11: `done` is high for exactly one cycle per accepted load. While it is high, at most one fault flag is set, and `fault_code` is zero.
- R12: A load request made while `busy` is high is ignored. A memory request is held, with a stable address, until `mem_rdy`.
- R13: After reset, `busy`, `done`, `mem_req`, both fault flags and all cache outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_req | input | 1 | Start a descriptor load (taken when idle) |
| ld_sel | input | 16 | Selector; bits 15..3 index the table |
| ld_target | input | 2 | 00/11 data register, 01 code register, 10 stack register |
| tbl_base | input | 32 | Table base byte address |
| tbl_limit | input | 32 | Last valid byte offset in the table |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a word write |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with mem_rdy |
| mem_rdy | input | 1 | Access completes this cycle |
| busy | output | 1 | A load is in progress |
| done | output | 1 | One-cycle completion pulse |
| fault_gp | output | 1 | General protection fault for the last load |
| fault_np | output | 1 | Not-present fault for the last load |
| fault_code | output | 16 | Error code for the fault, zero |
| cache_base | output | 32 | Segment base |
| cache_limit | output | 32 | Segment byte limit |
| cache_access | output | 8 | Access byte with accessed bit set |
| cache_dpl | output | 2 | Descriptor privilege level |
| cache_gran | output | 1 | Granularity bit |
| cache_big | output | 1 | Default size / big bit |
| cache_avl | output | 1 | Software-available bit |

## Verification
A stuck or skipped sequencer state shows up directly in the memory trace. Each load should produce a fixed pattern of four reads and at most one write, and a wrong count or order is visible at the port within a few cycles of the request. A wrong field slice or legality decision first appears in the cycle `done` rises, as a wrong cache value or a wrong fault flag. An accessed-bit error stays hidden until memory is read back, so the bench compares the stored descriptor bytes after each load. Memory stalls are exercised so that an address that moves before `mem_rdy`, or a second request taken while busy, corrupts the trace.

// File: rtl/seg_desc_pkg.sv
package seg_desc_pkg;

  localparam int unsigned DESC_BYTES = 8;
  localparam int unsigned DESC_WORDS = DESC_BYTES / 2;
  localparam int unsigned RAW_W      = DESC_BYTES * 8;

  // access byte bit positions
  localparam int unsigned AB_PRESENT = 7;
  localparam int unsigned AB_SEG     = 4;
  localparam int unsigned AB_EXEC    = 3;
  localparam int unsigned AB_RW      = 1;
  localparam int unsigned AB_USED    = 0;

  typedef enum logic [1:0] {
    TGT_DATA  = 2'b00,
    TGT_CODE  = 2'b01,
    TGT_STACK = 2'b10,
    TGT_DATAX = 2'b11
  } seg_target_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_CHECK,
    ST_WBACK,
    ST_DONE
  } ld_state_e;

endpackage

// File: rtl/desc_limit_expand.sv
module desc_limit_expand #(
  parameter int unsigned FIELD_W = 20,
  parameter int unsigned SHIFT   = 12,
  parameter int unsigned OUT_W   = 32
) (
  input  logic [FIELD_W-1:0] field,
  input  logic               gran,
  output logic [OUT_W-1:0]   limit
);
  localparam logic [OUT_W-1:0] FILL = (OUT_W'(1) << SHIFT) - OUT_W'(1);

  logic [OUT_W-1:0] wide;
  assign wide = OUT_W'(field);

  always_comb begin
    if (gran) limit = (wide << SHIFT) | FILL;
    else      limit = wide;
  end
endmodule

// File: rtl/desc_unpack.sv
module desc_unpack
  import seg_desc_pkg::*;
#(
  parameter int unsigned LIM_FIELD_W = 20,
  parameter int unsigned PAGE_SHIFT  = 12
) (
  input  logic [RAW_W-1:0] raw,
  output logic [31:0]      base,
  output logic [31:0]      limit,
  output logic [7:0]       access,
  output logic             gran,
  output logic             big,
  output logic             avl
);
  logic [LIM_FIELD_W-1:0] lim_field;

  // byte k of the descriptor sits at raw[8k+7:8k]
  assign base      = {raw[63:56], raw[39:16]};
  assign access    = raw[47:40];
  assign gran      = raw[55];
  assign big       = raw[54];
  assign avl       = raw[52];
  assign lim_field = LIM_FIELD_W'({raw[51:48], raw[15:0]});

  desc_limit_expand #(
    .FIELD_W(LIM_FIELD_W),
    .SHIFT  (PAGE_SHIFT),
    .OUT_W  (32)
  ) u_expand (
    .field(lim_field),
    .gran (gran),
    .limit(limit)
  );
endmodule

// File: rtl/desc_rights_check.sv
module desc_rights_check
  import seg_desc_pkg::*;
(
  input  logic [7:0] access,
  input  logic [1:0] target,
  output logic       type_bad,
  output logic       not_present
);
  logic is_seg, is_exec, rw;
  seg_target_e tgt;

  assign is_seg  = access[AB_SEG];
  assign is_exec = access[AB_EXEC];
  assign rw      = access[AB_RW];
  assign tgt     = seg_target_e'(target);

  always_comb begin
    type_bad = 1'b0;
    if (!is_seg) begin
      type_bad = 1'b1;
    end else begin
      unique case (tgt)
        TGT_CODE:  type_bad = !is_exec;
        TGT_STACK: type_bad = is_exec || !rw;
        default:   type_bad = is_exec && !rw;
      endcase
    end
  end

  assign not_present = !access[AB_PRESENT];
endmodule

// File: rtl/desc_fetch_ctrl.sv
module desc_fetch_ctrl
  import seg_desc_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_req,
  input  logic [15:0]       ld_sel,
  input  logic [1:0]        ld_target,
  input  logic [ADDR_W-1:0] tbl_base,
  input  logic [ADDR_W-1:0] tbl_limit,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [15:0]       mem_wdata,
  input  logic [15:0]       mem_rdata,
  input  logic              mem_rdy,
  input  logic              type_bad,
  input  logic              not_present,
  input  logic              used_clear,
  input  logic [15:0]       wb_word,
  output logic [RAW_W-1:0]  desc_raw,
  output logic [1:0]        tgt_q,
  output logic              commit,
  output logic              busy,
  output logic              done,
  output logic              fault_gp,
  output logic              fault_np
);
  localparam int unsigned CNT_W = $clog2(DESC_WORDS);

  ld_state_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [ADDR_W-1:0] daddr_q, daddr_d;
  logic [1:0]        tgt_d;
  logic              gp_q, gp_d, np_q, np_d;
  logic [ADDR_W-1:0] desc_off, desc_last;
  logic              range_bad, word_we;
  logic [15:0]       words_q [DESC_WORDS];

  assign desc_off  = ADDR_W'({ld_sel[15:3], 3'b000});
  assign desc_last = desc_off | ADDR_W'(DESC_BYTES - 1);
  assign range_bad = desc_last > tbl_limit;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    daddr_d = daddr_q;
    tgt_d   = tgt_q;
    gp_d    = gp_q;
    np_d    = np_q;
    unique case (state_q)
      ST_IDLE: begin
        if (ld_req) begin
          daddr_d = tbl_base + desc_off;
          tgt_d   = ld_target;
          cnt_d   = '0;
          gp_d    = range_bad;
          np_d    = 1'b0;
          state_d = range_bad ? ST_DONE : ST_READ;
        end
      end
      ST_READ: begin
        if (mem_rdy) begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == CNT_W'(DESC_WORDS - 1)) state_d = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (type_bad) begin
          gp_d    = 1'b1;
          state_d = ST_DONE;
        end else if (not_present) begin
          np_d    = 1'b1;
          state_d = ST_DONE;
        end else begin
          state_d = used_clear ? ST_WBACK : ST_DONE;
        end
      end
      ST_WBACK: if (mem_rdy) state_d = ST_DONE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      daddr_q <= '0;
      tgt_q   <= '0;
      gp_q    <= 1'b0;
      np_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      daddr_q <= daddr_d;
      tgt_q   <= tgt_d;
      gp_q    <= gp_d;
      np_q    <= np_d;
    end
  end

  assign word_we = (state_q == ST_READ) && mem_rdy;

  for (genvar g = 0; g < DESC_WORDS; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               words_q[g] <= '0;
      else if (word_we && cnt_q == CNT_W'(g))   words_q[g] <= mem_rdata;
    end
    assign desc_raw[16*g +: 16] = words_q[g];
  end

  assign mem_req   = (state_q == ST_READ) || (state_q == ST_WBACK);
  assign mem_we    = (state_q == ST_WBACK);
  assign mem_addr  = daddr_q + (mem_we ? ADDR_W'(4) : ADDR_W'({cnt_q, 1'b0}));
  assign mem_wdata = wb_word;
  assign commit    = (state_q == ST_CHECK) && !type_bad && !not_present;
  assign busy      = (state_q != ST_IDLE);
  assign done      = (state_q == ST_DONE);
  assign fault_gp  = gp_q;
  assign fault_np  = np_q;

  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r11_one_fault: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(fault_gp && fault_np));
  a_r12_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  a_r12_load_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> ($stable(daddr_q) && $stable(tgt_q)));
  a_r9_no_write_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !(fault_gp || fault_np));
endmodule

// File: rtl/seg_desc_loader.sv
module seg_desc_loader
  import seg_desc_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned LIM_FIELD_W = 20,
  parameter int unsigned PAGE_SHIFT  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_req,
  input  logic [15:0]       ld_sel,
  input  logic [1:0]        ld_target,
  input  logic [ADDR_W-1:0] tbl_base,
  input  logic [ADDR_W-1:0] tbl_limit,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [15:0]       mem_wdata,
  input  logic [15:0]       mem_rdata,
  input  logic              mem_rdy,
  output logic              busy,
  output logic              done,
  output logic              fault_gp,
  output logic              fault_np,
  output logic [15:0]       fault_code,
  output logic [31:0]       cache_base,
  output logic [31:0]       cache_limit,
  output logic [7:0]        cache_access,
  output logic [1:0]        cache_dpl,
  output logic              cache_gran,
  output logic              cache_big,
  output logic              cache_avl
);
  logic [RAW_W-1:0] desc_raw;
  logic [1:0]       tgt_q;
  logic [31:0]      dec_base, dec_limit;
  logic [7:0]       dec_access;
  logic             dec_gran, dec_big, dec_avl;
  logic             type_bad, not_present, commit;
  logic [15:0]      wb_word;

  assign wb_word = {dec_access | 8'h01, desc_raw[39:32]};

  desc_fetch_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ld_req     (ld_req),
    .ld_sel     (ld_sel),
    .ld_target  (ld_target),
    .tbl_base   (tbl_base),
    .tbl_limit  (tbl_limit),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_rdata  (mem_rdata),
    .mem_rdy    (mem_rdy),
    .type_bad   (type_bad),
    .not_present(not_present),
    .used_clear (!dec_access[AB_USED]),
    .wb_word    (wb_word),
    .desc_raw   (desc_raw),
    .tgt_q      (tgt_q),
    .commit     (commit),
    .busy       (busy),
    .done       (done),
    .fault_gp   (fault_gp),
    .fault_np   (fault_np)
  );

  desc_unpack #(
    .LIM_FIELD_W(LIM_FIELD_W),
    .PAGE_SHIFT (PAGE_SHIFT)
  ) u_unpack (
    .raw   (desc_raw),
    .base  (dec_base),
    .limit (dec_limit),
    .access(dec_access),
    .gran  (dec_gran),
    .big   (dec_big),
    .avl   (dec_avl)
  );

  desc_rights_check u_rights (
    .access     (dec_access),
    .target     (tgt_q),
    .type_bad   (type_bad),
    .not_present(not_present)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cache_base   <= '0;
      cache_limit  <= '0;
      cache_access <= '0;
      cache_dpl    <= '0;
      cache_gran   <= 1'b0;
      cache_big    <= 1'b0;
      cache_avl    <= 1'b0;
    end else if (commit) begin
      cache_base   <= dec_base;
      cache_limit  <= dec_limit;
      cache_access <= dec_access | 8'h01;
      cache_dpl    <= dec_access[6:5];
      cache_gran   <= dec_gran;
      cache_big    <= dec_big;
      cache_avl    <= dec_avl;
    end
  end

  assign fault_code = '0;

  a_r3_gran_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fault_gp && !fault_np && cache_gran) |-> (cache_limit[PAGE_SHIFT-1:0] == '1));
  a_r2_cache_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy) |=> $stable(cache_base) && $stable(cache_limit));
endmodule

// File: tb/seg_desc_loader_bench.sv
module seg_desc_loader_bench;
  localparam logic [31:0] TB_BASE  = 32'h0000_0080;
  localparam logic [31:0] TB_LIMIT = 32'h0000_003F;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        ld_req = 1'b0;
  logic [15:0] ld_sel = '0;
  logic [1:0]  ld_target = '0;
  logic        mem_req, mem_we, mem_rdy;
  logic [31:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata, fault_code;
  logic        busy, done, fault_gp, fault_np;
  logic [31:0] cache_base, cache_limit;
  logic [7:0]  cache_access;
  logic [1:0]  cache_dpl;
  logic        cache_gran, cache_big, cache_avl;

  seg_desc_loader u_seg_desc_loader (
    .clk(clk), .rst_n(rst_n), .ld_req(ld_req), .ld_sel(ld_sel), .ld_target(ld_target),
    .tbl_base(TB_BASE), .tbl_limit(TB_LIMIT),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_rdy(mem_rdy),
    .busy(busy), .done(done), .fault_gp(fault_gp), .fault_np(fault_np), .fault_code(fault_code),
    .cache_base(cache_base), .cache_limit(cache_limit), .cache_access(cache_access),
    .cache_dpl(cache_dpl), .cache_gran(cache_gran), .cache_big(cache_big), .cache_avl(cache_avl)
  );

  // word memory model with optional stalls
  logic [15:0] mem [512];
  logic        stall_en = 1'b0;
  logic [1:0]  stall_ctr = '0;
  logic [31:0] log_addr [16];
  logic        log_we [16];
  logic [15:0] log_wd [16];
  int          log_n = 0;

  assign mem_rdy   = mem_req && (!stall_en || stall_ctr == 2'b11);
  assign mem_rdata = mem[mem_addr[9:1]];

  always @(posedge clk) begin
    stall_ctr <= stall_ctr + 2'd1;
    if (mem_req && mem_rdy) begin
      if (mem_we) mem[mem_addr[9:1]] = mem_wdata;
      if (log_n < 16) begin
        log_addr[log_n] = mem_addr;
        log_we[log_n]   = mem_we;
        log_wd[log_n]   = mem_wdata;
      end
      log_n = log_n + 1;
    end
  end

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_limit(input logic [19:0] f, input logic g);
    return g ? {f, 12'hFFF} : {12'h000, f};
  endfunction

  function automatic int widx(input int idx);
    return int'((TB_BASE + 32'(idx) * 8) >> 1);
  endfunction

  task automatic put_desc(input int idx, input logic [19:0] lim, input logic [31:0] base,
                          input logic [7:0] acc, input logic [3:0] fl);
    int w;
    w = widx(idx);
    mem[w]     = lim[15:0];
    mem[w + 1] = base[15:0];
    mem[w + 2] = {acc, base[23:16]};
    mem[w + 3] = {base[31:24], fl, lim[19:16]};
  endtask

  logic r_gp, r_np;

  task automatic do_load(input int idx, input logic [2:0] low, input logic [1:0] tgt);
    int n;
    @(negedge clk);
    log_n = 0;
    ld_sel = {13'(idx), low};
    ld_target = tgt;
    ld_req = 1'b1;
    @(negedge clk);
    ld_req = 1'b0;
    n = 0;
    while (!done && n < 200) begin
      @(negedge clk);
      n++;
    end
    chk("R11 done seen", {63'b0, done}, 64'd1);
    r_gp = fault_gp;
    r_np = fault_np;
    chk("R11 fault_code zero", {48'b0, fault_code}, 64'd0);
    chk("R11 single fault", {63'b0, fault_gp && fault_np}, 64'd0);
    @(negedge clk);
    chk("R11 done one cycle", {63'b0, done}, 64'd0);
  endtask

  task automatic expect_reads(input string tag, input int idx, input int total);
    logic [31:0] d;
    d = TB_BASE + 32'(idx) * 8;
    chk({tag, " access count"}, 64'(log_n), 64'(total));
    for (int k = 0; k < 4; k++) begin
      chk({tag, " read addr"}, {32'b0, log_addr[k]}, {32'b0, d + 32'(2 * k)});
      chk({tag, " read kind"}, {63'b0, log_we[k]}, 64'd0);
    end
  endtask

  task automatic t_reset;
    chk("R13 busy", {63'b0, busy}, 0);
    chk("R13 done", {63'b0, done}, 0);
    chk("R13 mem_req", {63'b0, mem_req}, 0);
    chk("R13 faults", {62'b0, fault_gp, fault_np}, 0);
    chk("R13 cache", {cache_base, cache_limit}, 0);
    chk("R13 cache attr", {51'b0, cache_access, cache_dpl, cache_gran, cache_big, cache_avl}, 0);
  endtask

  task automatic t_basic;
    int w;
    put_desc(3, 20'hABCDE, 32'h1234_5678, 8'hD2, 4'b0101);
    do_load(3, 3'b111, 2'b00);
    chk("R2 ok", {62'b0, r_gp, r_np}, 0);
    chk("R2 base", {32'b0, cache_base}, {32'b0, 32'h1234_5678});
    chk("R3 limit g0", {32'b0, cache_limit}, {32'b0, exp_limit(20'hABCDE, 1'b0)});
    chk("R2 access", {56'b0, cache_access}, 64'hD3);
    chk("R2 dpl", {62'b0, cache_dpl}, 64'd2);
    chk("R2 flags", {61'b0, cache_gran, cache_big, cache_avl}, 64'b011);
    expect_reads("R1", 3, 5);
    chk("R9 write kind", {63'b0, log_we[4]}, 64'd1);
    chk("R9 write addr", {32'b0, log_addr[4]}, {32'b0, TB_BASE + 32'd28});
    chk("R9 write data", {48'b0, log_wd[4]}, {48'b0, 16'hD334});
    w = widx(3);
    chk("R9 memory updated", {48'b0, mem[w + 2]}, {48'b0, 16'hD334});
    chk("R9 other word kept", {48'b0, mem[w + 3]}, {48'b0, 16'h125A});
  endtask

  task automatic t_gran;
    put_desc(1, 20'h00000, 32'h0, 8'h97, 4'b1000);
    do_load(1, 3'b000, 2'b10);
    chk("R3 g1 zero expand-down", {32'b0, cache_limit}, {32'b0, 32'h0000_0FFF});
    put_desc(2, 20'h12345, 32'hFFFF_0000, 8'h93, 4'b1100);
    do_load(2, 3'b000, 2'b00);
    chk("R3 g1 field", {32'b0, cache_limit}, {32'b0, exp_limit(20'h12345, 1'b1)});
    chk("R9 no write when used", 64'(log_n), 64'd4);
  endtask

  task automatic t_code;
    put_desc(4, 20'h0FFFF, 32'h0001_0000, 8'h98, 4'b0100);
    do_load(4, 3'b000, 2'b01);
    chk("R4 exec-only into code ok", {62'b0, r_gp, r_np}, 0);
    chk("R4 code base", {32'b0, cache_base}, {32'b0, 32'h0001_0000});
    put_desc(4, 20'h0FFFF, 32'h0002_0000, 8'h92, 4'b0100);
    do_load(4, 3'b000, 2'b01);
    chk("R4 data into code gp", {62'b0, r_gp, r_np}, 64'b10);
    chk("R4 cache kept", {32'b0, cache_base}, {32'b0, 32'h0001_0000});
    chk("R4 no write on fault", 64'(log_n), 64'd4);
  endtask

  task automatic t_stack;
    put_desc(5, 20'h00100, 32'h0000_4000, 8'h90, 4'b0);
    do_load(5, 3'b000, 2'b10);
    chk("R5 read-only gp", {62'b0, r_gp, r_np}, 64'b10);
    put_desc(5, 20'h00100, 32'h0000_4000, 8'h9A, 4'b0);
    do_load(5, 3'b000, 2'b10);
    chk("R5 code gp", {62'b0, r_gp, r_np}, 64'b10);
  endtask

  task automatic t_data;
    put_desc(6, 20'h00010, 32'h0000_5000, 8'h98, 4'b0);
    do_load(6, 3'b000, 2'b11);
    chk("R6 exec-only gp", {62'b0, r_gp, r_np}, 64'b10);
    put_desc(6, 20'h00010, 32'h0000_6000, 8'h9A, 4'b0);
    do_load(6, 3'b000, 2'b00);
    chk("R6 readable code ok", {62'b0, r_gp, r_np}, 0);
    chk("R6 base", {32'b0, cache_base}, {32'b0, 32'h0000_6000});
  endtask

  task automatic t_sys_np;
    put_desc(7, 20'h00010, 32'h0, 8'h82, 4'b0);
    do_load(7, 3'b000, 2'b00);
    chk("R7 system gp", {62'b0, r_gp, r_np}, 64'b10);
    put_desc(7, 20'h00010, 32'h0, 8'h12, 4'b0);
    do_load(7, 3'b000, 2'b00);
    chk("R8 not present", {62'b0, r_gp, r_np}, 64'b01);
    chk("R8 no write", 64'(log_n), 64'd4);
    put_desc(7, 20'h00010, 32'h0, 8'h18, 4'b0);
    do_load(7, 3'b000, 2'b00);
    chk("R8 type before present", {62'b0, r_gp, r_np}, 64'b10);
  endtask

  task automatic t_range;
    put_desc(7, 20'h00001, 32'h0000_7000, 8'h93, 4'b0);
    do_load(7, 3'b000, 2'b00);
    chk("R10 last index ok", {62'b0, r_gp, r_np}, 0);
    do_load(8, 3'b000, 2'b00);
    chk("R10 beyond limit gp", {62'b0, r_gp, r_np}, 64'b10);
    chk("R10 no memory access", 64'(log_n), 64'd0);
  endtask

  task automatic t_busy;
    int n;
    stall_en = 1'b1;
    put_desc(1, 20'h00ABC, 32'h0BAD_0000, 8'h92, 4'b0);
    put_desc(2, 20'h00DEF, 32'h0C0D_0000, 8'h92, 4'b0);
    @(negedge clk);
    log_n = 0;
    ld_sel = {13'd1, 3'b0};
    ld_target = 2'b00;
    ld_req = 1'b1;
    @(negedge clk);
    ld_req = 1'b0;
    repeat (3) @(negedge clk);
    ld_sel = {13'd2, 3'b0};
    ld_target = 2'b01;
    ld_req = 1'b1;
    @(negedge clk);
    ld_req = 1'b0;
    n = 0;
    while (!done && n < 200) begin @(negedge clk); n++; end
    chk("R12 first load finished", {62'b0, done, fault_gp}, 64'b10);
    chk("R12 first load base", {32'b0, cache_base}, {32'b0, 32'h0BAD_0000});
    expect_reads("R12 stalled", 1, 5);
    repeat (6) @(negedge clk);
    chk("R12 request ignored", {62'b0, busy, mem_req}, 0);
    chk("R12 no extra access", 64'(log_n), 64'd5);
    stall_en = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_basic();
    t_gran();
    t_code();
    t_stack();
    t_data();
    t_sys_np();
    t_range();
    t_busy();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule